// File: doc/BRIEF.md
# Bus Release Arbiter

This block sits in a processor's bus interface and decides when the external bus is handed to another master. Three mechanisms can take the bus away. A full hold request is acknowledged only when the bus is quiet. An address-hold request floats only the address lines, so an external master can drive an invalidation address. A backoff request floats the bus at once and does not acknowledge.

The bus cycle generator supplies two indications. One is a level that is high while a bus cycle or burst is in flight. The other is a single-clock strobe on the last ready of that cycle. The core supplies a lock level that covers a whole locked sequence. The arbiter drives a hold acknowledge, two float enables for the pad logic (address group, and all bus-hold-floated outputs) and a single-clock restart request. The restart request tells the cycle generator to rerun a cycle that a backoff cut off. All outputs are registered and all inputs are sampled on the rising clock edge. Reset is synchronous and active high.

Top module: `bus_release_arb`

## Requirements
- R1: While reset is sampled high, every output is low in the following clock.
- R2: Hold acknowledge rises only after an edge at which the hold request was high, the lock level low and the backoff request low. At that edge either no cycle was in flight or the in-flight cycle ended.
- R3: Hold acknowledge is low in the clock after an edge that samples the hold request low.
- R4: While the lock level is sampled high, a hold acknowledge that is not yet given is not given in the next clock.
- R5: A cycle in flight that does not end at a sampled edge blocks a new hold acknowledge in the next clock.
- R6: An address-hold request floats the address group in the next clock and leaves the full-bus float unaffected. This holds even while the lock level is high.
- R7: Whenever hold acknowledge is high, both the address float and the full-bus float are high in the same clock.
- R8: A sampled backoff request raises the full-bus float (and the address float) in the next clock and never raises hold acknowledge. A cycle end seen at the same edge as backoff does not count as an end.
- R9: If a cycle was in flight at any edge during a backoff, the restart request is high for exactly one clock. That clock follows the first edge that samples backoff low.
- R10: A backoff during which no cycle was in flight produces no restart request.
- R11: When hold and backoff overlap, the float follows backoff and no acknowledge is given. The acknowledge is given only after backoff is negated, the restart request has been issued and the restarted cycle has ended.
- R12: A backoff arriving while hold is already acknowledged leaves the acknowledge high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hold_req | input | 1 | Full bus hold request from another master |
| ahold_req | input | 1 | Address-only hold request |
| boff_req | input | 1 | Backoff request, active high |
| lock_active | input | 1 | Core is inside a locked sequence |
| cyc_busy | input | 1 | A bus cycle or burst is in flight |
| cyc_end | input | 1 | Last ready of the in-flight cycle |
| hold_ack | output | 1 | Hold acknowledge |
| addr_float | output | 1 | Float enable for address lines |
| bus_float | output | 1 | Float enable for all hold-floated outputs |
| restart_req | output | 1 | One-clock request to rerun a backed-off cycle |

## Verification
The block has no size parameters, so the bench builds the single fixed configuration and spends its effort on orderings. A vector walk covers these cases:
- address hold under lock;
- a hold that waits out a lock and then a busy cycle;
- backoff colliding with a cycle end in the same clock;
- backoff with and without a cycle in flight;
- hold overlapping backoff through the restart;
- backoff arriving during an acknowledged hold.

Directed checks then cover the reset state and a reset that arrives in the middle of a hold.

// File: rtl/bra_pkg.sv
package bra_pkg;

  typedef enum logic {
    HS_OWN   = 1'b0,
    HS_YIELD = 1'b1
  } hold_state_e;

endpackage

// File: rtl/bra_backoff_ctrl.sv
module bra_backoff_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic boff_req,
  input  logic cyc_busy,
  output logic restart_block,
  output logic restart_req
);

  logic boff_q;
  logic pend_q;
  logic fire;

  assign fire = boff_q && !boff_req && pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      boff_q      <= 1'b0;
      pend_q      <= 1'b0;
      restart_req <= 1'b0;
    end else begin
      boff_q      <= boff_req;
      restart_req <= fire;
      if (fire)
        pend_q <= 1'b0;
      else if (boff_req && cyc_busy)
        pend_q <= 1'b1;
    end
  end

  assign restart_block = pend_q || restart_req;

  assert_restart_follows_negation_R9: assert property (@(posedge clk) disable iff (rst)
    restart_req |-> (!$past(boff_req) && $past(boff_req, 2)));

  assert_restart_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    restart_req |=> !restart_req);

  assert_no_restart_while_boff_R10: assert property (@(posedge clk) disable iff (rst)
    boff_req |=> !restart_req);

endmodule

// File: rtl/bra_hold_ctrl.sv
module bra_hold_ctrl
  import bra_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hold_req,
  input  logic lock_active,
  input  logic cyc_busy,
  input  logic cyc_end,
  input  logic boff_req,
  input  logic restart_block,
  output logic hold_next,
  output logic hold_ack
);

  hold_state_e state_q, state_d;
  logic        bus_quiet;
  logic        may_grant;

  assign bus_quiet = !cyc_busy || cyc_end;
  assign may_grant = !lock_active && bus_quiet && !boff_req && !restart_block;

  always_comb begin
    state_d = state_q;
    case (state_q)
      HS_OWN:   if (hold_req && may_grant) state_d = HS_YIELD;
      HS_YIELD: if (!hold_req)             state_d = HS_OWN;
      default:                             state_d = HS_OWN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= HS_OWN;
    else     state_q <= state_d;
  end

  assign hold_next = (state_d == HS_YIELD);
  assign hold_ack  = (state_q == HS_YIELD);

  assert_grant_conditions_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> $past(hold_req && !lock_active && !boff_req && (!cyc_busy || cyc_end)));

  assert_release_on_drop_R3: assert property (@(posedge clk) disable iff (rst)
    !hold_req |=> !hold_ack);

  assert_lock_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (lock_active && !hold_ack) |=> !hold_ack);

  assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    (cyc_busy && !cyc_end && !hold_ack) |=> !hold_ack);

  assert_boff_no_ack_R8: assert property (@(posedge clk) disable iff (rst)
    (boff_req && !hold_ack) |=> !hold_ack);

  assert_ack_kept_under_boff_R12: assert property (@(posedge clk) disable iff (rst)
    (hold_ack && hold_req) |=> hold_ack);

endmodule

// File: rtl/bra_float_ctrl.sv
module bra_float_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic hold_next,
  input  logic boff_req,
  input  logic ahold_req,
  output logic bus_float,
  output logic addr_float
);

  logic bus_d;

  assign bus_d = hold_next || boff_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_float  <= 1'b0;
      addr_float <= 1'b0;
    end else begin
      bus_float  <= bus_d;
      addr_float <= bus_d || ahold_req;
    end
  end

  assert_ahold_floats_addr_R6: assert property (@(posedge clk) disable iff (rst)
    ahold_req |=> addr_float);

  assert_boff_floats_bus_R8: assert property (@(posedge clk) disable iff (rst)
    boff_req |=> (bus_float && addr_float));

  assert_bus_implies_addr_R7: assert property (@(posedge clk) disable iff (rst)
    bus_float |-> addr_float);

endmodule

// File: rtl/bus_release_arb.sv
module bus_release_arb (
  input  logic clk,
  input  logic rst,
  input  logic hold_req,
  input  logic ahold_req,
  input  logic boff_req,
  input  logic lock_active,
  input  logic cyc_busy,
  input  logic cyc_end,
  output logic hold_ack,
  output logic addr_float,
  output logic bus_float,
  output logic restart_req
);

  logic restart_block;
  logic hold_next;

  bra_backoff_ctrl u_boff (
    .clk           (clk),
    .rst           (rst),
    .boff_req      (boff_req),
    .cyc_busy      (cyc_busy),
    .restart_block (restart_block),
    .restart_req   (restart_req)
  );

  bra_hold_ctrl u_hold (
    .clk           (clk),
    .rst           (rst),
    .hold_req      (hold_req),
    .lock_active   (lock_active),
    .cyc_busy      (cyc_busy),
    .cyc_end       (cyc_end),
    .boff_req      (boff_req),
    .restart_block (restart_block),
    .hold_next     (hold_next),
    .hold_ack      (hold_ack)
  );

  bra_float_ctrl u_float (
    .clk        (clk),
    .rst        (rst),
    .hold_next  (hold_next),
    .boff_req   (boff_req),
    .ahold_req  (ahold_req),
    .bus_float  (bus_float),
    .addr_float (addr_float)
  );

  assert_ack_floats_all_R7: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> (bus_float && addr_float));

  assert_restart_blocks_ack_R11: assert property (@(posedge clk) disable iff (rst)
    (restart_req && !hold_ack) |=> !hold_ack);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> !(hold_ack || addr_float || bus_float || restart_req));

endmodule

// File: tb/bus_release_arb_tb.sv
module bus_release_arb_tb_top;

  logic clk = 1'b0;
  logic rst;
  logic hold_req, ahold_req, boff_req, lock_active, cyc_busy, cyc_end;
  logic hold_ack, addr_float, bus_float, restart_req;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bus_release_arb dut_i (
    .clk         (clk),
    .rst         (rst),
    .hold_req    (hold_req),
    .ahold_req   (ahold_req),
    .boff_req    (boff_req),
    .lock_active (lock_active),
    .cyc_busy    (cyc_busy),
    .cyc_end     (cyc_end),
    .hold_ack    (hold_ack),
    .addr_float  (addr_float),
    .bus_float   (bus_float),
    .restart_req (restart_req)
  );

  // inputs {hold, ahold, boff, lock, busy, end}, expected {ack, addr, bus, restart}
  localparam logic [9:0] VEC [0:30] = '{
    10'b000000_0000, // R1 idle
    10'b010000_0100, // R6 address hold
    10'b010100_0100, // R6 address hold under lock
    10'b000000_0000,
    10'b100110_0000, // R4 lock blocks
    10'b100010_0000, // R5 busy blocks
    10'b100011_1110, // R2 grant at cycle end, R7
    10'b100000_1110,
    10'b000000_0000, // R3 release
    10'b001010_0110, // R8 backoff with cycle
    10'b001011_0110, // R8 end ignored under backoff
    10'b000010_0001, // R9 restart pulse
    10'b000010_0000, // R9 single pulse
    10'b000011_0000,
    10'b001000_0110, // R10 idle backoff
    10'b000000_0000, // R10 no restart
    10'b101010_0110, // R11 hold + backoff
    10'b101000_0110, // R11
    10'b100000_0001, // R11 restart, no ack
    10'b100010_0000, // R11 restart blocks
    10'b100011_1110, // R11 ack after restarted cycle
    10'b101000_1110, // R12 backoff during hold
    10'b100000_1110, // R12
    10'b110000_1110,
    10'b000000_0000, // R3
    10'b100000_1110, // R2 immediate grant when quiet
    10'b010000_0100, // R6
    10'b000000_0000,
    10'b100100_0000, // R4 lock between locked cycles
    10'b100000_1110, // R2
    10'b000000_0000  // R3
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs {ack,addr,bus,restart} = %b, expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] v);
    {hold_req, ahold_req, boff_req, lock_active, cyc_busy, cyc_end} = v;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: expired, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(6'b000000);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", {hold_ack, addr_float, bus_float, restart_req}, 4'b0000);
    rst = 1'b0;

    for (int i = 0; i < 31; i++) begin
      drive(VEC[i][9:4]);
      @(negedge clk);
      check($sformatf("R1-R12 vector %0d", i),
            {hold_ack, addr_float, bus_float, restart_req}, VEC[i][3:0]);
    end

    // reset in the middle of a hold with backoff and address hold (R1)
    drive(6'b100000);
    @(negedge clk);
    check("R2 grant before reset", {hold_ack, addr_float, bus_float, restart_req}, 4'b1110);
    drive(6'b111010);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-hold", {hold_ack, addr_float, bus_float, restart_req}, 4'b0000);
    rst = 1'b0;
    drive(6'b000000);
    @(negedge clk);
    check("R10 no restart after reset", {hold_ack, addr_float, bus_float, restart_req}, 4'b0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule